// File: doc/BRIEF.md
# Outbound Descriptor-Chain DMA Engine

This engine moves data from memory to a byte-stream consumer by following a linked list of data descriptors. Each descriptor occupies four consecutive 32-bit words in memory. Word 0 holds the address of the next descriptor, word 1 the start of the buffer, and word 2 the end of the buffer (exclusive). Word 3 holds flags: bit 0 end-of-list, bit 2 interrupt request, bit 3 end-of-packet and bit 4 reserved for the inbound direction. The engine reads the descriptor, streams the buffer bytes to a valid/ready consumer, writes the descriptor back and then moves to the next descriptor or halts.

A transfer is launched with a descriptor address, a resume pointer into that descriptor's buffer and the address of a context word. The first buffer is sent from the resume pointer, not from its start field, so an interrupted transfer can pick up where it stopped. At the end of the list the engine marks the context disabled and halts. Software can later clear the end-of-list flag of the last descriptor, link in more descriptors and issue a continue. The engine then re-reads that descriptor, follows its next pointer and carries on.

Memory is reached through one word-wide request/acknowledge port that carries both reads and writes. The engine holds the pointer state only. Interrupt masking and register storage belong to the surrounding logic, which receives a one-cycle interrupt pulse.

Top module: `outbound_chain_dma`

## Requirements
- R1: After reset the engine is idle. `running_o`, `eol_o`, `tx_valid_o`, `mem_req_o` and `irq_o` are all 0.
- R2: A `start_i` pulse while idle or halted reads the four descriptor words at `desc_addr_i`+0, +4, +8 and +12, and sets `data_ptr_o` to `desc_addr_i`. The first buffer is sent from `buf_ptr_i`, not from the descriptor's buffer-start field.
- R3: The bytes from the buffer pointer up to end-1 are sent in ascending address order. The byte at address a is lane a[1:0] of the word at a>>2, little-endian. `buf_ptr_o` advances by one for each byte the consumer accepts. While `tx_ready_i` is low, the data and the pointer hold.
- R4: `tx_eop_o` is asserted with the last byte of a buffer only when flag bit 3 of that descriptor is set. It is never asserted on any other byte.
- R5: Each completed descriptor whose flag bit 2 is set produces exactly one single-cycle `irq_o` pulse.
- R6: On completion, the four descriptor words are written back unchanged to the descriptor address.
- R7: When flag bit 0 of a completed descriptor is clear, `data_ptr_o` takes the next field, that descriptor is fetched, and its bytes are sent starting from its buffer-start field.
- R8: When flag bit 0 of a completed descriptor is set, the engine writes 0x00000001 (disable bit 0) to `ctx_addr_i`, sets `eol_o`, drops `running_o`, and makes no further memory or stream activity.
- R9: A descriptor whose buffer pointer already equals its end field sends no bytes but still completes: it is written back, raises the interrupt if enabled and follows the chain.
- R10: A `continue_i` pulse while halted at end-of-list re-reads the descriptor at `data_ptr_o`. If its flag bit 0 is now clear, the engine clears `eol_o`, moves to its next descriptor and sends from that descriptor's buffer-start field. If the flag is still set, the engine halts again with no bytes sent.
- R11: A `continue_i` pulse while idle and not at end-of-list has no effect: no memory access, and `running_o` stays 0.
- R12: A memory request holds its address, direction and write data until `mem_ack_i`. Results are the same with acknowledge wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a chain from `desc_addr_i` |
| continue_i | input | 1 | Resume after end-of-list |
| desc_addr_i | input | AW | First descriptor address |
| buf_ptr_i | input | AW | Resume pointer into first buffer |
| ctx_addr_i | input | AW | Context word address |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| tx_data_o | output | 8 | Stream byte |
| tx_eop_o | output | 1 | Last byte of packet |
| tx_valid_o | output | 1 | Byte valid |
| tx_ready_i | input | 1 | Consumer accepts byte |
| irq_o | output | 1 | Descriptor-done interrupt pulse |
| running_o | output | 1 | Engine busy |
| eol_o | output | 1 | Halted at end-of-list |
| data_ptr_o | output | AW | Current descriptor address |
| buf_ptr_o | output | AW | Current buffer pointer |

## Verification
Single descriptors are run from a table that varies the resume offset, the length, the word alignment and the flags. One entry has a zero length, and the table also applies consumer stalls, memory wait states and both together. Byte order, lane selection, EOP placement and interrupt counts can therefore be told apart from any effect of back-pressure. A three-descriptor chain that starts mid-buffer separates the resume pointer from the buffer-start field used for every later descriptor. Continue is exercised while idle, while the end-of-list flag is still set, and after software has cleared that flag and linked in a new descriptor.

// File: rtl/ocd_pkg.sv
package ocd_pkg;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned W_NEXT  = 0;
  localparam int unsigned W_BUF   = 1;
  localparam int unsigned W_AFTER = 2;
  localparam int unsigned W_FLAGS = 3;
  localparam int unsigned F_EOL  = 0;
  localparam int unsigned F_INTR = 2;
  localparam int unsigned F_EOP  = 3;
  localparam logic [31:0] CTX_DISABLE = 32'h0000_0001;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_EVAL, S_CHECK, S_LOAD, S_SEND, S_WB_DESC, S_WB_CTX, S_HALT
  } state_e;

  typedef enum logic [1:0] {M_START, M_NEXT, M_CONT} fmode_e;
endpackage

// File: rtl/dma_desc_store.sv
module dma_desc_store
  import ocd_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             ld_i,
  input  logic [1:0]                       idx_i,
  input  logic [31:0]                      word_i,
  output logic [DESC_WORDS-1:0][31:0]      words_o,
  output logic [AW-1:0]                    next_o,
  output logic [AW-1:0]                    buf_o,
  output logic [AW-1:0]                    after_o,
  output logic                             eol_o,
  output logic                             eop_o,
  output logic                             intr_o
);
  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else if (ld_i && idx_i == 2'(g)) word_q <= word_i;
    end
    assign words_o[g] = word_q;
  end

  assign next_o  = words_o[W_NEXT][AW-1:0];
  assign buf_o   = words_o[W_BUF][AW-1:0];
  assign after_o = words_o[W_AFTER][AW-1:0];
  assign eol_o   = words_o[W_FLAGS][F_EOL];
  assign eop_o   = words_o[W_FLAGS][F_EOP];
  assign intr_o  = words_o[W_FLAGS][F_INTR];
endmodule

// File: rtl/dma_byte_lane.sv
module dma_byte_lane #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inval_i,
  input  logic          ld_i,
  input  logic [31:0]   word_i,
  input  logic [AW-1:0] ptr_i,
  output logic          hit_o,
  output logic [7:0]    byte_o
);
  localparam int unsigned WAW = AW - 2;

  logic [WAW-1:0]  tag_q;
  logic            vld_q;
  logic [3:0][7:0] lanes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q   <= '0;
      vld_q   <= 1'b0;
      lanes_q <= '0;
    end else if (inval_i) begin
      vld_q <= 1'b0;
    end else if (ld_i) begin
      tag_q   <= ptr_i[AW-1:2];
      vld_q   <= 1'b1;
      lanes_q <= word_i;
    end
  end

  assign hit_o  = vld_q && (tag_q == ptr_i[AW-1:2]);
  assign byte_o = lanes_q[ptr_i[1:0]];
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import ocd_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        continue_i,
  input  logic [AW-1:0]               desc_addr_i,
  input  logic [AW-1:0]               buf_ptr_i,
  input  logic [AW-1:0]               ctx_addr_i,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [AW-1:0]               mem_addr_o,
  output logic [31:0]                 mem_wdata_o,
  input  logic                        mem_ack_i,
  input  logic [DESC_WORDS-1:0][31:0] d_words_i,
  input  logic [AW-1:0]               d_next_i,
  input  logic [AW-1:0]               d_buf_i,
  input  logic [AW-1:0]               d_after_i,
  input  logic                        d_eol_i,
  input  logic                        d_eop_i,
  input  logic                        d_intr_i,
  output logic                        desc_ld_o,
  output logic [1:0]                  desc_idx_o,
  input  logic                        lane_hit_i,
  input  logic [7:0]                  lane_byte_i,
  output logic                        lane_ld_o,
  output logic                        lane_inval_o,
  output logic [7:0]                  tx_data_o,
  output logic                        tx_eop_o,
  output logic                        tx_valid_o,
  input  logic                        tx_ready_i,
  output logic                        irq_o,
  output logic                        running_o,
  output logic                        eol_o,
  output logic [AW-1:0]               data_ptr_o,
  output logic [AW-1:0]               buf_ptr_o
);
  state_e        state_q;
  fmode_e        mode_q;
  logic [1:0]    idx_q;
  logic [AW-1:0] data_ptr_q, buf_ptr_q, ctx_q;
  logic          eol_q, irq_q;
  logic [AW-1:0] buf_nxt;
  logic [AW-1:0] word_off;

  assign buf_nxt  = buf_ptr_q + AW'(1);
  assign word_off = AW'({idx_q, 2'b00});

  always_comb begin
    mem_req_o   = state_q inside {S_FETCH, S_LOAD, S_WB_DESC, S_WB_CTX};
    mem_we_o    = state_q inside {S_WB_DESC, S_WB_CTX};
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      S_FETCH:   mem_addr_o = data_ptr_q + word_off;
      S_LOAD:    mem_addr_o = {buf_ptr_q[AW-1:2], 2'b00};
      S_WB_DESC: begin
        mem_addr_o  = data_ptr_q + word_off;
        mem_wdata_o = d_words_i[idx_q];
      end
      S_WB_CTX: begin
        mem_addr_o  = ctx_q;
        mem_wdata_o = CTX_DISABLE;
      end
      default: ;
    endcase
  end

  assign desc_ld_o    = (state_q == S_FETCH) && mem_ack_i;
  assign desc_idx_o   = idx_q;
  assign lane_ld_o    = (state_q == S_LOAD) && mem_ack_i;
  assign lane_inval_o = (state_q == S_FETCH);
  assign tx_valid_o   = (state_q == S_SEND);
  assign tx_data_o    = lane_byte_i;
  assign tx_eop_o     = tx_valid_o && d_eop_i && (buf_nxt == d_after_i);
  assign irq_o        = irq_q;
  assign running_o    = !(state_q inside {S_IDLE, S_HALT});
  assign eol_o        = eol_q;
  assign data_ptr_o   = data_ptr_q;
  assign buf_ptr_o    = buf_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      mode_q     <= M_START;
      idx_q      <= '0;
      data_ptr_q <= '0;
      buf_ptr_q  <= '0;
      ctx_q      <= '0;
      eol_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (state_q)
        S_IDLE, S_HALT: begin
          if (start_i) begin
            data_ptr_q <= desc_addr_i;
            buf_ptr_q  <= buf_ptr_i;
            ctx_q      <= ctx_addr_i;
            eol_q      <= 1'b0;
            mode_q     <= M_START;
            idx_q      <= '0;
            state_q    <= S_FETCH;
          end else if (continue_i && eol_q) begin
            mode_q  <= M_CONT;
            idx_q   <= '0;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack_i) begin
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd3) state_q <= S_EVAL;
        end
        S_EVAL: begin
          case (mode_q)
            M_CONT: begin
              if (!d_eol_i) begin
                data_ptr_q <= d_next_i;
                mode_q     <= M_NEXT;
                eol_q      <= 1'b0;
                state_q    <= S_FETCH;
              end else begin
                state_q <= S_HALT;
              end
            end
            M_NEXT: begin
              buf_ptr_q <= d_buf_i;
              state_q   <= S_CHECK;
            end
            default: state_q <= S_CHECK;
          endcase
        end
        S_CHECK: begin
          if (buf_ptr_q == d_after_i) begin
            irq_q   <= d_intr_i;
            state_q <= S_WB_DESC;
          end else if (lane_hit_i) begin
            state_q <= S_SEND;
          end else begin
            state_q <= S_LOAD;
          end
        end
        S_LOAD: if (mem_ack_i) state_q <= S_SEND;
        S_SEND: if (tx_ready_i) begin
          buf_ptr_q <= buf_nxt;
          if (buf_nxt == d_after_i)      state_q <= S_CHECK;
          else if (buf_nxt[1:0] == 2'b0) state_q <= S_LOAD;
        end
        S_WB_DESC: if (mem_ack_i) begin
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd3) begin
            if (d_eol_i) begin
              eol_q   <= 1'b1;
              state_q <= S_WB_CTX;
            end else begin
              data_ptr_q <= d_next_i;
              mode_q     <= M_NEXT;
              state_q    <= S_FETCH;
            end
          end
        end
        S_WB_CTX: if (mem_ack_i) state_q <= S_HALT;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r3_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(buf_ptr_o));
  a_r3_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i |=> buf_ptr_o == $past(buf_ptr_o) + AW'(1));
  a_r4_eop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_eop_o |=> !tx_valid_o);
  a_r5_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r8_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o && !running_o |-> !mem_req_o && !tx_valid_o);
  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));
endmodule

// File: rtl/outbound_chain_dma.sv
module outbound_chain_dma
  import ocd_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          continue_i,
  input  logic [AW-1:0] desc_addr_i,
  input  logic [AW-1:0] buf_ptr_i,
  input  logic [AW-1:0] ctx_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_eop_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic          irq_o,
  output logic          running_o,
  output logic          eol_o,
  output logic [AW-1:0] data_ptr_o,
  output logic [AW-1:0] buf_ptr_o
);
  logic [DESC_WORDS-1:0][31:0] d_words;
  logic [AW-1:0] d_next, d_buf, d_after;
  logic          d_eol, d_eop, d_intr;
  logic          desc_ld;
  logic [1:0]    desc_idx;
  logic          lane_hit, lane_ld, lane_inval;
  logic [7:0]    lane_byte;

  dma_desc_store #(.AW(AW)) u_desc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (desc_ld),
    .idx_i   (desc_idx),
    .word_i  (mem_rdata_i),
    .words_o (d_words),
    .next_o  (d_next),
    .buf_o   (d_buf),
    .after_o (d_after),
    .eol_o   (d_eol),
    .eop_o   (d_eop),
    .intr_o  (d_intr)
  );

  dma_byte_lane #(.AW(AW)) u_lane (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inval_i (lane_inval),
    .ld_i    (lane_ld),
    .word_i  (mem_rdata_i),
    .ptr_i   (buf_ptr_o),
    .hit_o   (lane_hit),
    .byte_o  (lane_byte)
  );

  dma_chain_ctrl #(.AW(AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .continue_i   (continue_i),
    .desc_addr_i  (desc_addr_i),
    .buf_ptr_i    (buf_ptr_i),
    .ctx_addr_i   (ctx_addr_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .d_words_i    (d_words),
    .d_next_i     (d_next),
    .d_buf_i      (d_buf),
    .d_after_i    (d_after),
    .d_eol_i      (d_eol),
    .d_eop_i      (d_eop),
    .d_intr_i     (d_intr),
    .desc_ld_o    (desc_ld),
    .desc_idx_o   (desc_idx),
    .lane_hit_i   (lane_hit),
    .lane_byte_i  (lane_byte),
    .lane_ld_o    (lane_ld),
    .lane_inval_o (lane_inval),
    .tx_data_o    (tx_data_o),
    .tx_eop_o     (tx_eop_o),
    .tx_valid_o   (tx_valid_o),
    .tx_ready_i   (tx_ready_i),
    .irq_o        (irq_o),
    .running_o    (running_o),
    .eol_o        (eol_o),
    .data_ptr_o   (data_ptr_o),
    .buf_ptr_o    (buf_ptr_o)
  );
endmodule

// File: tb/outbound_chain_dma_tb.sv
module outbound_chain_dma_tb;
  localparam int AW = 32;
  localparam logic [31:0] CTX = 32'h3F0;
  localparam int NV = 5;
  localparam int V_BASE [NV] = '{32'h800, 32'h811, 32'h823, 32'h830, 32'h845};
  localparam int V_SKIP [NV] = '{0, 2, 0, 4, 1};
  localparam int V_LEN  [NV] = '{8, 7, 1, 4, 10};
  localparam int V_FLAG [NV] = '{9, 5, 13, 13, 9};
  localparam int V_STALL[NV] = '{0, 1, 2, 0, 3};

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 0, cont = 0;
  logic [31:0] desc_addr = 0, bptr = 0;
  logic mem_req, mem_we, mem_ack, tx_eop, tx_valid, tx_ready, irq, running, eol;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, data_ptr, buf_ptr;
  logic [7:0] tx_data;

  logic rdy_wait = 0, ack_wait = 0, rdy_tog = 0, ack_tog = 0;
  logic tb_we = 0;
  logic [9:0] tb_wa = 0;
  logic [31:0] tb_wd = 0;
  logic [31:0] mem [0:1023];

  logic [7:0] cap_data [0:1023];
  logic       cap_eop  [0:1023];
  int cap_n = 0, irq_n = 0, acc_n = 0, ctx_n = 0, dwr_n = 0;
  logic [31:0] ctx_last = 0;
  int n_checks = 0, n_fail = 0;

  outbound_chain_dma #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .continue_i(cont),
    .desc_addr_i(desc_addr), .buf_ptr_i(bptr), .ctx_addr_i(CTX),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .tx_data_o(tx_data), .tx_eop_o(tx_eop), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .irq_o(irq), .running_o(running), .eol_o(eol),
    .data_ptr_o(data_ptr), .buf_ptr_o(buf_ptr)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    pat = 8'(a[7:0] * 8'd7) + a[15:8] + 8'h5A;
  endfunction

  function automatic logic [31:0] init_word(input int w);
    logic [31:0] b;
    b = 32'(w) << 2;
    init_word = {pat(b + 3), pat(b + 2), pat(b + 1), pat(b)};
  endfunction

  assign mem_ack   = mem_req && (!ack_wait || ack_tog);
  assign tx_ready  = !rdy_wait || rdy_tog;
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(negedge clk) begin
    rdy_tog <= ~rdy_tog;
    ack_tog <= ~ack_tog;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= init_word(i);
    end else begin
      if (tb_we) mem[tb_wa] <= tb_wd;
      if (mem_req && mem_ack) begin
        acc_n <= acc_n + 1;
        if (mem_we) begin
          mem[mem_addr[11:2]] <= mem_wdata;
          if (mem_addr == CTX) begin
            ctx_n    <= ctx_n + 1;
            ctx_last <= mem_wdata;
          end else begin
            dwr_n <= dwr_n + 1;
          end
        end
      end
      if (tx_valid && tx_ready) begin
        cap_data[cap_n] <= tx_data;
        cap_eop[cap_n]  <= tx_eop;
        cap_n <= cap_n + 1;
      end
      if (irq) irq_n <= irq_n + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1; tb_wa = a[11:2]; tb_wd = d;
    @(negedge clk);
    tb_we = 0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] bf,
                          input logic [31:0] af, input logic [31:0] fl);
    poke(a, nx); poke(a + 4, bf); poke(a + 8, af); poke(a + 12, fl);
  endtask

  task automatic wait_halt();
    int k;
    k = 0;
    @(negedge clk);
    while (running && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(k < 5000, "R8 engine halts", 32'(k), 32'd5000);
    repeat (2) @(negedge clk);
  endtask

  task automatic launch(input logic [31:0] d, input logic [31:0] p);
    @(negedge clk);
    desc_addr = d; bptr = p; start = 1;
    @(negedge clk);
    start = 0;
    wait_halt();
  endtask

  task automatic pulse_cont();
    @(negedge clk);
    cont = 1;
    @(negedge clk);
    cont = 0;
  endtask

  // Compare a run of captured bytes with the expected address sequence.
  task automatic check_seg(input int i0, input logic [31:0] a0, input int n, input logic eop_exp,
                           input string tag);
    int bad_d, bad_e;
    bad_d = 0; bad_e = 0;
    for (int i = 0; i < n; i++) begin
      if (cap_data[i0 + i] !== pat(a0 + 32'(i))) bad_d++;
      if (cap_eop[i0 + i] !== ((i == n - 1) && eop_exp)) bad_e++;
    end
    chk(bad_d == 0, {tag, " R3 byte data"}, 32'(bad_d), 0);
    chk(bad_e == 0, {tag, " R4 eop placement"}, 32'(bad_e), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail + 1);
    $finish;
  end

  initial begin
    int c0, i0, a0, d0, x0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!running && !eol && !tx_valid && !mem_req && !irq, "R1 reset idle",
        {27'd0, running, eol, tx_valid, mem_req, irq}, 0);

    // R11 continue while idle
    a0 = acc_n;
    pulse_cont();
    repeat (8) @(negedge clk);
    chk(acc_n == a0 && !running, "R11 idle continue ignored", 32'(acc_n - a0), 0);

    // Table of single-descriptor runs
    for (int v = 0; v < NV; v++) begin
      logic [31:0] base, after;
      int n;
      rdy_wait = V_STALL[v][0];
      ack_wait = V_STALL[v][1];
      base  = 32'(V_BASE[v]);
      after = base + 32'(V_LEN[v]);
      n     = V_LEN[v] - V_SKIP[v];
      put_desc(32'h200, 32'h0, base, after, 32'(V_FLAG[v]));
      c0 = cap_n; i0 = irq_n; x0 = ctx_n; d0 = dwr_n;
      launch(32'h200, base + 32'(V_SKIP[v]));
      chk(cap_n - c0 == n, $sformatf("R3 v%0d byte count", v), 32'(cap_n - c0), 32'(n));
      if (n == 0) chk(cap_n == c0, $sformatf("R9 v%0d zero length sends nothing", v), 32'(cap_n - c0), 0);
      check_seg(c0, base + 32'(V_SKIP[v]), n, V_FLAG[v][3], $sformatf("v%0d", v));
      chk(irq_n - i0 == V_FLAG[v][2], $sformatf("R5 v%0d irq count", v), 32'(irq_n - i0), 32'(V_FLAG[v][2]));
      chk(buf_ptr == after, $sformatf("R3 v%0d final pointer", v), buf_ptr, after);
      chk(data_ptr == 32'h200, $sformatf("R2 v%0d data pointer", v), data_ptr, 32'h200);
      chk(dwr_n - d0 == 4, $sformatf("R6 v%0d descriptor writeback", v), 32'(dwr_n - d0), 4);
      chk(eol && ctx_n - x0 == 1 && ctx_last == 32'h1, $sformatf("R8 v%0d context disable", v),
          ctx_last, 32'h1);
      if (V_STALL[v][1]) chk(cap_n - c0 == n, $sformatf("R12 v%0d wait states", v), 32'(cap_n - c0), 32'(n));
    end
    rdy_wait = 0; ack_wait = 0;

    // R7 chain of three, starting mid-buffer in the first
    put_desc(32'h100, 32'h120, 32'h400, 32'h405, 32'hC);
    put_desc(32'h120, 32'h140, 32'h503, 32'h50A, 32'h0);
    put_desc(32'h140, 32'h0,   32'h600, 32'h602, 32'h9);
    c0 = cap_n; i0 = irq_n; d0 = dwr_n;
    launch(32'h100, 32'h402);
    chk(cap_n - c0 == 12, "R7 chain byte count", 32'(cap_n - c0), 12);
    check_seg(c0,     32'h402, 3, 1'b1, "R7 seg1");
    check_seg(c0 + 3, 32'h503, 7, 1'b0, "R7 seg2");
    check_seg(c0 + 10, 32'h600, 2, 1'b1, "R7 seg3");
    chk(irq_n - i0 == 1, "R5 chain irq count", 32'(irq_n - i0), 1);
    chk(dwr_n - d0 == 12, "R6 chain writebacks", 32'(dwr_n - d0), 12);
    chk(mem[32'h14C >> 2] == 32'h9, "R6 flags word unchanged", mem[32'h14C >> 2], 32'h9);
    chk(data_ptr == 32'h140 && buf_ptr == 32'h602, "R7 final pointers", data_ptr, 32'h140);

    // R10 continue with end-of-list still set
    c0 = cap_n;
    pulse_cont();
    wait_halt();
    chk(eol && cap_n == c0 && data_ptr == 32'h140, "R10 continue while eol set", 32'(cap_n - c0), 0);

    // R10 continue after eol cleared and a new descriptor linked
    rdy_wait = 1;
    put_desc(32'h160, 32'h0, 32'h700, 32'h704, 32'hD);
    poke(32'h140, 32'h160);
    poke(32'h14C, 32'h8);
    c0 = cap_n; i0 = irq_n;
    pulse_cont();
    @(negedge clk);
    chk(running, "R10 continue restarts", {31'd0, running}, 1);
    wait_halt();
    chk(cap_n - c0 == 4, "R10 continued byte count", 32'(cap_n - c0), 4);
    check_seg(c0, 32'h700, 4, 1'b1, "R10 continued");
    chk(irq_n - i0 == 1 && eol && data_ptr == 32'h160, "R10 halted at new tail", data_ptr, 32'h160);
    rdy_wait = 0;

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule